// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the effective memory address and the updated base register value for a single-register load or store. The offset is either a 12-bit unsigned immediate or an index register passed through a barrel shifter. The shifter has four shift kinds, and a zero shift amount selects a special case for each kind. A direction bit adds the offset to the base or subtracts it. An indexing-mode bit chooses between two forms. In the pre-indexed form the adjusted value is used for the access. In the post-indexed form the untouched base is used for the access, and the adjusted value becomes the new base.

The datapath is combinational. A parameter-selected output stage registers the three results, and it is enabled by default. Memory access, byte-lane steering and alignment are handled outside the block.

Top module: `lsu_agu`

## Requirements
- R1: With `use_reg_i`=0, the offset is `imm_i` zero-extended (0 to 4095). It is added to the base when `add_i`=1 and subtracted when `add_i`=0.
- R2: With `pre_i`=1, `addr_o` equals base plus or minus the offset.
- R3: `new_base_o` always carries base plus or minus the offset. `base_we_o` is 1 for post-indexed accesses and for pre-indexed accesses with `wb_i`=1, and 0 for pre-indexed accesses with `wb_i`=0.
- R4: With `pre_i`=0, `addr_o` equals the unmodified base and `new_base_o` equals base plus or minus the offset.
- R5: `shift_type_i`=00 is a logical left shift by `shift_amt_i` (0 to 31). An amount of 0 leaves the index unchanged.
- R6: `shift_type_i`=01 is a logical right shift by 1 to 31. An amount of 0 means a shift by 32, which gives 0.
- R7: `shift_type_i`=10 is an arithmetic right shift, which rounds toward minus infinity. An amount of 0 means a shift by 32, which fills every bit with the index sign bit.
- R8: `shift_type_i`=11 rotates right by 1 to 31. An amount of 0 rotates right by one bit through the carry: `carry_i` enters bit 31 and index bit 0 is dropped.
- R9: All address arithmetic wraps modulo 2^32.
- R10: With the default registered output, results appear on the first rising clock edge after the inputs. While `rst_ni` is low, all outputs are 0.
- R11: With `use_reg_i`=1, the shifted index is the offset and `imm_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base register value |
| imm_i | input | 12 | Immediate offset magnitude |
| index_i | input | 32 | Index register value |
| use_reg_i | input | 1 | 1: shifted index offset, 0: immediate offset |
| shift_type_i | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR/RRX |
| shift_amt_i | input | 5 | Encoded shift amount |
| carry_i | input | 1 | Carry input for rotate-through-carry |
| add_i | input | 1 | 1: add offset, 0: subtract offset |
| pre_i | input | 1 | 1: pre-indexed, 0: post-indexed |
| wb_i | input | 1 | Writeback request for pre-indexed form |
| addr_o | output | 32 | Access address |
| new_base_o | output | 32 | Adjusted base value |
| base_we_o | output | 1 | Base register write enable |

## Verification
Any fault in the shifter or the adder shows up on `new_base_o` one clock after the inputs are applied. If the indexing-mode selection is wrong, `addr_o` disagrees with either the base or `new_base_o`, and this too is visible one clock later. The corner cases are checked with directed stimulus, because an error there is otherwise easy to miss: zero-amount shift encodings, rounding of negative index values under ASR, carry insertion under RRX, and wrap-around at both ends of the address space.

// File: rtl/lsu_agu_pkg.sv
package lsu_agu_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/lsu_agu_shifter.sv
module lsu_agu_shifter
  import lsu_agu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]  idx_i,
  input  shift_kind_e        kind_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  logic               carry_i,
  output logic [DATA_W-1:0]  res_o
);
  localparam int unsigned AW = SHAMT_W + 1;

  logic              amt_zero;
  logic [AW-1:0]     back_amt;
  logic [DATA_W-1:0] lsl_v, lsr_v, asr_v, ror_v;

  assign amt_zero = (amt_i == '0);
  assign back_amt = AW'(DATA_W) - AW'(amt_i);

  always_comb begin
    lsl_v = idx_i << amt_i;
    // zero amount encodes a full-width right shift
    lsr_v = amt_zero ? '0 : (idx_i >> amt_i);
    asr_v = amt_zero ? {DATA_W{idx_i[DATA_W-1]}}
                     : DATA_W'($signed(idx_i) >>> amt_i);
    // zero amount encodes one-bit rotate through carry
    ror_v = amt_zero ? {carry_i, idx_i[DATA_W-1:1]}
                     : ((idx_i >> amt_i) | (idx_i << back_amt));
    unique case (kind_i)
      SH_LSL:  res_o = lsl_v;
      SH_LSR:  res_o = lsr_v;
      SH_ASR:  res_o = asr_v;
      default: res_o = ror_v;
    endcase
  end
endmodule

// File: rtl/lsu_agu_adder.sv
module lsu_agu_adder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [DATA_W-1:0] off_i,
  input  logic              add_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W-1:0] off_inv;

  // subtract as base + ~off + 1, wraps modulo 2^DATA_W
  assign off_inv = add_i ? off_i : ~off_i;
  assign sum_o   = base_i + off_inv + DATA_W'(!add_i);
endmodule

// File: rtl/lsu_agu_out_stage.sv
module lsu_agu_out_stage #(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] addr_d_i,
  input  logic [DATA_W-1:0] nb_d_i,
  input  logic              we_d_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] nb_o,
  output logic              we_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o <= '0;
        nb_o   <= '0;
        we_o   <= 1'b0;
      end else begin
        addr_o <= addr_d_i;
        nb_o   <= nb_d_i;
        we_o   <= we_d_i;
      end
    end
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign addr_o = addr_d_i;
    assign nb_o   = nb_d_i;
    assign we_o   = we_d_i;
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu
  import lsu_agu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 12,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned SHAMT_W = $clog2(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DATA_W-1:0]  base_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [DATA_W-1:0]  index_i,
  input  logic               use_reg_i,
  input  logic [1:0]         shift_type_i,
  input  logic [SHAMT_W-1:0] shift_amt_i,
  input  logic               carry_i,
  input  logic               add_i,
  input  logic               pre_i,
  input  logic               wb_i,
  output logic [DATA_W-1:0]  addr_o,
  output logic [DATA_W-1:0]  new_base_o,
  output logic               base_we_o
);
  logic [DATA_W-1:0] shifted, imm_ext, offset, adjusted, addr_d;
  logic              we_d;

  lsu_agu_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
    .idx_i   (index_i),
    .kind_i  (shift_kind_e'(shift_type_i)),
    .amt_i   (shift_amt_i),
    .carry_i (carry_i),
    .res_o   (shifted)
  );

  assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
  assign offset  = use_reg_i ? shifted : imm_ext;

  lsu_agu_adder #(.DATA_W(DATA_W)) u_add (
    .base_i (base_i),
    .off_i  (offset),
    .add_i  (add_i),
    .sum_o  (adjusted)
  );

  assign addr_d = pre_i ? adjusted : base_i;
  assign we_d   = !pre_i || wb_i;

  lsu_agu_out_stage #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_d_i (addr_d),
    .nb_d_i   (adjusted),
    .we_d_i   (we_d),
    .addr_o   (addr_o),
    .nb_o     (new_base_o),
    .we_o     (base_we_o)
  );
endmodule

// File: rtl/lsu_agu_chk.sv
module lsu_agu_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IMM_W   = 12,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] base_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              use_reg_i,
  input logic              pre_i,
  input logic              wb_i,
  input logic [DATA_W-1:0] addr_o,
  input logic [DATA_W-1:0] new_base_o,
  input logic              base_we_o
);
  if (REG_OUT) begin : g_chk
    logic seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        assert_reset_zero_R10: assert (addr_o == '0 && new_base_o == '0 && !base_we_o);
      end
    end

    assert_post_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !$past(pre_i) |-> addr_o == $past(base_i));

    assert_pre_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(pre_i) |-> addr_o == new_base_o);

    assert_post_we_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !$past(pre_i) |-> base_we_o);

    assert_pre_nowb_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && $past(pre_i) && !$past(wb_i) |-> !base_we_o);

    assert_imm_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q && !$past(use_reg_i) && $past(imm_i) == '0 |-> new_base_o == $past(base_i));
  end else begin : g_none
    logic unused;
    assign unused = ^{clk_i, rst_ni, base_i, imm_i, use_reg_i, pre_i, wb_i,
                      addr_o, new_base_o, base_we_o};
  end
endmodule

bind lsu_agu lsu_agu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .base_i     (base_i),
  .imm_i      (imm_i),
  .use_reg_i  (use_reg_i),
  .pre_i      (pre_i),
  .wb_i       (wb_i),
  .addr_o     (addr_o),
  .new_base_o (new_base_o),
  .base_we_o  (base_we_o)
);

// File: tb/lsu_agu_tb.sv
module lsu_agu_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] base_i = '0, index_i = '0;
  logic [11:0] imm_i = '0;
  logic        use_reg_i = 1'b0, carry_i = 1'b0, add_i = 1'b1, pre_i = 1'b1, wb_i = 1'b0;
  logic [1:0]  shift_type_i = 2'b00;
  logic [4:0]  shift_amt_i = '0;
  logic [31:0] addr_o, new_base_o;
  logic        base_we_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  lsu_agu u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .base_i(base_i), .imm_i(imm_i),
    .index_i(index_i), .use_reg_i(use_reg_i), .shift_type_i(shift_type_i),
    .shift_amt_i(shift_amt_i), .carry_i(carry_i), .add_i(add_i),
    .pre_i(pre_i), .wb_i(wb_i), .addr_o(addr_o), .new_base_o(new_base_o),
    .base_we_o(base_we_o)
  );

  task automatic chk(string req, logic [31:0] ea, logic [31:0] enb, logic ewe);
    checks++;
    if (addr_o !== ea || new_base_o !== enb || base_we_o !== ewe) begin
      fails++;
      $display("FAIL %s: addr=%h nb=%h we=%b expected addr=%h nb=%h we=%b",
               req, addr_o, new_base_o, base_we_o, ea, enb, ewe);
    end
  endtask

  // apply inputs at a falling edge, sample one falling edge later
  task automatic imm_op(logic [31:0] b, logic [11:0] im, logic ad, logic pr, logic w);
    use_reg_i = 1'b0; base_i = b; imm_i = im; add_i = ad; pre_i = pr; wb_i = w;
    @(negedge clk_i);
  endtask

  task automatic reg_op(logic [31:0] b, logic [31:0] ix, logic [1:0] k, logic [4:0] a,
                        logic c, logic ad);
    use_reg_i = 1'b1; base_i = b; index_i = ix; shift_type_i = k; shift_amt_i = a;
    carry_i = c; add_i = ad; pre_i = 1'b1; wb_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk("R10 reset", 32'h0, 32'h0, 1'b0);
  endtask

  task automatic t_imm;
    imm_op(32'h1000, 12'hFFF, 1'b1, 1'b1, 1'b1);
    chk("R1 R2 imm add", 32'h1FFF, 32'h1FFF, 1'b1);
    imm_op(32'h1000, 12'd300, 1'b0, 1'b1, 1'b0);
    chk("R1 R3 imm sub no wb", 32'h0ED4, 32'h0ED4, 1'b0);
  endtask

  task automatic t_post;
    imm_op(32'h2000, 12'd8, 1'b1, 1'b0, 1'b0);
    chk("R4 post add", 32'h2000, 32'h2008, 1'b1);
    imm_op(32'h2000, 12'd16, 1'b0, 1'b0, 1'b1);
    chk("R4 post sub", 32'h2000, 32'h1FF0, 1'b1);
  endtask

  task automatic t_lsl;
    reg_op(32'h0, 32'h1, 2'b00, 5'd31, 1'b0, 1'b1);
    chk("R5 lsl31", 32'h8000_0000, 32'h8000_0000, 1'b1);
    reg_op(32'h10, 32'h1234, 2'b00, 5'd0, 1'b0, 1'b1);
    chk("R5 lsl0", 32'h1244, 32'h1244, 1'b1);
  endtask

  task automatic t_lsr;
    reg_op(32'h0, 32'h8000_0000, 2'b01, 5'd4, 1'b0, 1'b1);
    chk("R6 lsr4", 32'h0800_0000, 32'h0800_0000, 1'b1);
    reg_op(32'h55, 32'hFFFF_FFFF, 2'b01, 5'd0, 1'b1, 1'b1);
    chk("R6 lsr32", 32'h55, 32'h55, 1'b1);
  endtask

  task automatic t_asr;
    reg_op(32'h100, 32'hFFFF_FFF0, 2'b10, 5'd2, 1'b0, 1'b1);
    chk("R7 asr -16/4", 32'hFC, 32'hFC, 1'b1);
    reg_op(32'h100, 32'hFFFF_FFF9, 2'b10, 5'd2, 1'b0, 1'b1);
    chk("R7 asr -7 floor", 32'hFE, 32'hFE, 1'b1);
    reg_op(32'h100, 32'h8000_0000, 2'b10, 5'd0, 1'b0, 1'b0);
    chk("R7 asr32 sub", 32'h101, 32'h101, 1'b1);
  endtask

  task automatic t_ror;
    reg_op(32'h0, 32'h11, 2'b11, 5'd4, 1'b0, 1'b1);
    chk("R8 ror4", 32'h1000_0001, 32'h1000_0001, 1'b1);
    reg_op(32'h0, 32'h3, 2'b11, 5'd0, 1'b1, 1'b1);
    chk("R8 rrx c1", 32'h8000_0001, 32'h8000_0001, 1'b1);
    reg_op(32'h0, 32'h3, 2'b11, 5'd0, 1'b0, 1'b1);
    chk("R8 rrx c0", 32'h1, 32'h1, 1'b1);
  endtask

  task automatic t_wrap;
    imm_op(32'hFFFF_FFF0, 12'h20, 1'b1, 1'b1, 1'b1);
    chk("R9 wrap up", 32'h10, 32'h10, 1'b1);
    imm_op(32'h8, 12'h10, 1'b0, 1'b0, 1'b0);
    chk("R9 wrap down", 32'h8, 32'hFFFF_FFF8, 1'b1);
  endtask

  task automatic t_sel;
    imm_i = 12'hFFF;
    reg_op(32'h0, 32'h4, 2'b00, 5'd0, 1'b0, 1'b1);
    chk("R11 imm ignored", 32'h4, 32'h4, 1'b1);
    imm_op(32'h0, 12'hFFF, 1'b1, 1'b1, 1'b1);
    chk("R11 imm selected", 32'hFFF, 32'hFFF, 1'b1);
  endtask

  task automatic t_latency;
    imm_op(32'h3000, 12'd4, 1'b1, 1'b1, 1'b0);
    base_i = 32'h4000;
    #1;
    chk("R10 holds before edge", 32'h3004, 32'h3004, 1'b0);
    @(negedge clk_i);
    chk("R10 after edge", 32'h4004, 32'h4004, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_imm;
    t_post;
    t_lsl;
    t_lsr;
    t_asr;
    t_ror;
    t_wrap;
    t_sel;
    t_latency;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule